// File: doc/BRIEF.md
# Byte-Serial Receive Port with Request Handshake

This block is the receiving end of a byte-oriented serial link in which the block itself generates the serial clock. It divides the system clock into a serial clock and emits one-cycle enable pulses that mark each rising and each falling serial edge. It asks the sending framer for bytes through a request line. It recognises the start of each byte by a one-period byte strobe, and it shifts the data line in most significant bit first. Each completed byte is delivered on a parallel output for one system cycle.

Frames are opened by a frame strobe that the block drives on a rising serial edge. A programmed byte count limits how many bytes are requested within one frame. A downstream buffer signals whether it has room for another byte, and no request is made without that room. The request is final at one point per byte: the falling edge that follows the capture of bit 1. On that edge the block decides whether the next byte may follow without a gap. A byte strobe that arrives with no request outstanding is discarded and raises a sticky error flag.

Top module: `serial_byte_sink`

## Requirements
- R1: `sclk` is low after reset and toggles every `HALF_DIV` system cycles. `sclk_rise` is high for exactly the one system cycle whose closing edge drives `sclk` high, and `sclk_fall` is high for the one whose closing edge drives it low.
- R2: While reset is held, `sclk`, `frm`, `dreq`, `byte_valid`, `byte_last` and `strobe_err` are all low.
- R3: A `frame_req` pulse makes `frm` go high on the next rising serial edge and stay high for one serial period. The same edge clears the frame's byte count.
- R4: `dreq` rises only on a falling serial edge, and only when a frame has been opened, the byte count is below `frame_bytes`, and `buf_ready` is high. Once raised, it stays high until a byte strobe is accepted.
- R5: A rising edge that sees `bs` high while `dreq` is high captures bit 7 from `sdata`. The next seven rising edges capture bits 6 down to 0. The edge that captures bit 0 also presents the byte on `byte_data` with `byte_valid` high for one system cycle.
- R6: During a byte, `dreq` is low on every falling edge except the one that follows the capture of bit 1. On that edge it is set high exactly when the frame is open, `buf_ready` is high, and the count including the current byte is below `frame_bytes`. This lets the next strobe arrive on the rising edge right after bit 0.
- R7: At most `frame_bytes` bytes are requested per frame. `byte_last` is high together with `byte_valid` on the byte that brings the count up to `frame_bytes`, and only then. A count of 0 produces no requests.
- R8: A `bs` seen high on a rising edge while no byte is in progress and `dreq` is low delivers no byte and sets `strobe_err`, which then stays high until reset.
- R9: A `bs` pulse while a byte is being shifted in has no effect: the byte completes with its own data and `strobe_err` does not change.
- R10: Before the first frame strobe, `dreq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_req | input | 1 | One-cycle request to open a new frame |
| frame_bytes | input | CNT_W | Number of bytes to fetch per frame |
| buf_ready | input | 1 | Downstream has room for one more byte |
| sclk | output | 1 | Serial clock shared by both link directions |
| sclk_rise | output | 1 | Enable pulse in the cycle before `sclk` rises |
| sclk_fall | output | 1 | Enable pulse in the cycle before `sclk` falls |
| frm | output | 1 | Frame strobe, one serial period long |
| dreq | output | 1 | Data request to the sender |
| bs | input | 1 | Byte strobe from the sender, marks bit 7 |
| sdata | input | 1 | Serial data, MSB first |
| byte_data | output | 8 | Assembled byte |
| byte_valid | output | 1 | One-cycle qualifier for `byte_data` |
| byte_last | output | 1 | Byte completes the programmed frame count |
| strobe_err | output | 1 | Sticky flag for an unrequested strobe |

## Verification
Every result of this block changes on the system edge that closes an enable cycle. `frm`, the byte capture, `byte_valid` and `byte_last` change on a `sclk_rise` cycle, and `dreq` changes on a `sclk_fall` cycle. Each of them is therefore due one system edge after the enable is seen. The bench keeps its own divider and protocol model, which it advances at each system edge from the inputs it drove in that cycle. It compares every output half a cycle later, at the falling system edge, so each result is checked in exactly the cycle it is due. The bench plays the framer as well. It answers a request seen on one rising edge with a strobe sampled on the next, and it queues each byte it sends, so the expected byte data comes from the sender's record and not from the model.

// File: rtl/serial_byte_sink.sv
module serial_byte_sink #(
  parameter int HALF_DIV = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_req,
  input  logic [CNT_W-1:0] frame_bytes,
  input  logic             buf_ready,
  output logic             sclk,
  output logic             sclk_rise,
  output logic             sclk_fall,
  output logic             frm,
  output logic             dreq,
  input  logic             bs,
  input  logic             sdata,
  output logic [7:0]       byte_data,
  output logic             byte_valid,
  output logic             byte_last,
  output logic             strobe_err
);

  localparam int DW  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CW1 = CNT_W + 1;

  logic [DW-1:0]    div_cnt;
  logic             tick;
  logic             pend;
  logic             in_frame;
  logic [2:0]       bits_left;
  logic [6:0]       shreg;
  logic [CNT_W-1:0] cnt;
  logic             shifting;
  logic             want_now;
  logic             want_next;
  logic [CW1-1:0]   cnt_plus;

  assign tick      = (div_cnt == DW'(HALF_DIV - 1));
  assign sclk_rise = tick & ~sclk;
  assign sclk_fall = tick & sclk;
  assign shifting  = (bits_left != 3'd0);
  assign cnt_plus  = {1'b0, cnt} + CW1'(1);
  assign want_now  = in_frame & buf_ready & (cnt < frame_bytes);
  assign want_next = in_frame & buf_ready & (cnt_plus < {1'b0, frame_bytes});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sclk    <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      sclk    <= ~sclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      in_frame   <= 1'b0;
      frm        <= 1'b0;
      dreq       <= 1'b0;
      bits_left  <= 3'd0;
      shreg      <= '0;
      cnt        <= '0;
      byte_data  <= '0;
      byte_valid <= 1'b0;
      byte_last  <= 1'b0;
      strobe_err <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      byte_last  <= 1'b0;
      pend       <= (pend & ~sclk_rise) | frame_req;

      if (sclk_rise) begin
        frm <= pend;
        if (shifting) begin
          shreg     <= {shreg[5:0], sdata};
          bits_left <= bits_left - 3'd1;
          if (bits_left == 3'd1) begin
            byte_data  <= {shreg, sdata};
            byte_valid <= 1'b1;
            byte_last  <= (cnt_plus == {1'b0, frame_bytes});
          end
        end else if (bs) begin
          if (dreq) begin
            shreg     <= {6'b0, sdata};
            bits_left <= 3'd7;
          end else begin
            strobe_err <= 1'b1;
          end
        end
        if (pend) begin
          cnt      <= '0;
          in_frame <= 1'b1;
        end else if (bits_left == 3'd1) begin
          cnt <= cnt + 1'b1;
        end
      end

      if (sclk_fall) begin
        if (!shifting)              dreq <= dreq | want_now;
        else if (bits_left == 3'd1) dreq <= want_next;
        else                        dreq <= 1'b0;
      end
    end
  end

  a_r1_rise_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> sclk);
  a_r1_fall_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_fall |=> !sclk);
  a_r3_frm_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frm) || $fell(frm)) |-> $past(sclk_rise));
  a_r4_dreq_rises_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq) |-> $past(sclk_fall));
  a_r4_dreq_held_until_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && !shifting) |=> dreq);
  a_r5_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    byte_last |-> byte_valid);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err |=> strobe_err);

endmodule

// File: tb/test_serial_byte_sink.sv
module test_serial_byte_sink;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_req = 1'b0;
  logic [7:0] frame_bytes = 8'd0;
  logic buf_ready = 1'b0;
  logic bs = 1'b0;
  logic sdata = 1'b0;
  logic sclk, sclk_rise, sclk_fall, frm, dreq;
  logic [7:0] byte_data;
  logic byte_valid, byte_last, strobe_err;

  serial_byte_sink #(.HALF_DIV(H), .CNT_W(8)) i_serial_byte_sink (
    .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .frame_bytes(frame_bytes),
    .buf_ready(buf_ready), .sclk(sclk), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .frm(frm), .dreq(dreq), .bs(bs), .sdata(sdata), .byte_data(byte_data),
    .byte_valid(byte_valid), .byte_last(byte_last), .strobe_err(strobe_err));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  int c_div = 0;
  bit m_sclk = 0, m_frm = 0, m_dreq = 0, m_pend = 0, m_inf = 0, m_err = 0;
  bit m_valid = 0, m_last = 0;
  int m_bits = 0, m_cnt = 0;
  logic [7:0] m_data = 8'h00;
  logic [7:0] exp_q[$];

  int s_bits = 0;
  logic [7:0] s_byte = 8'h00;
  bit p_bs = 0, p_sd = 0, p_apply = 0;
  bit rnd_avail = 0, stray = 0, mid_inj = 0, fr_go = 0, rdy = 0;
  int next_val = 8'h5A;
  int seen_valid = 0, seen_last = 0;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit r, f, o_dreq, o_pend, o_inf;
    int o_bits, o_cnt;
    string dtag;
    r = (c_div == H - 1) && !m_sclk;
    f = (c_div == H - 1) && m_sclk;
    chk("R1", "sclk", sclk, m_sclk);
    chk("R1", "sclk_rise", sclk_rise, r);
    chk("R1", "sclk_fall", sclk_fall, f);
    chk("R3", "frm", frm, m_frm);
    dtag = !m_inf ? "R10" : (m_bits > 0 ? "R6" : "R4");
    chk(dtag, "dreq", dreq, m_dreq);
    chk("R5", "byte_valid", byte_valid, m_valid);
    if (m_valid) begin
      chk("R5", "byte_data", byte_data, m_data);
      chk("R7", "byte_last", byte_last, m_last);
    end
    if (byte_valid) seen_valid++;
    if (byte_valid && byte_last) seen_last++;
    chk("R8", "strobe_err", strobe_err, m_err);

    if (p_apply) begin
      bs = p_bs;
      sdata = p_sd;
      p_apply = 0;
    end
    frame_req = fr_go;
    fr_go = 0;
    buf_ready = rdy;

    o_dreq = m_dreq; o_pend = m_pend; o_inf = m_inf; o_bits = m_bits; o_cnt = m_cnt;
    m_valid = 0;
    m_last = 0;
    m_pend = (o_pend && !r) || frame_req;
    if (r) begin
      m_frm = o_pend;
      if (o_bits > 0) begin
        m_bits = o_bits - 1;
        if (o_bits == 1) begin
          m_valid = 1;
          m_data = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
          m_last = ((o_cnt + 1) == frame_bytes);
        end
      end else if (bs) begin
        if (o_dreq) m_bits = 7;
        else m_err = 1;
      end
      if (o_pend) begin
        m_cnt = 0;
        m_inf = 1;
      end else if (o_bits == 1) begin
        m_cnt = o_cnt + 1;
      end
    end
    if (f) begin
      if (o_bits == 0) m_dreq = o_dreq || (o_inf && rdy && o_cnt < frame_bytes);
      else if (o_bits == 1) m_dreq = o_inf && rdy && (o_cnt + 1) < frame_bytes;
      else m_dreq = 0;
    end

    if (r) begin
      p_apply = 1;
      p_bs = 0;
      p_sd = 1'($urandom);
      if (s_bits > 0) begin
        s_bits--;
        p_sd = s_byte[s_bits];
        if (mid_inj && s_bits == 4) begin
          p_bs = 1;
          mid_inj = 0;
        end
      end else if (o_dreq && (!rnd_avail || ($urandom % 4 != 0))) begin
        s_byte = 8'(next_val);
        next_val = next_val * 5 + 17;
        exp_q.push_back(s_byte);
        p_bs = 1;
        p_sd = s_byte[7];
        s_bits = 7;
      end else if (stray && !o_dreq) begin
        p_bs = 1;
        stray = 0;
      end
    end

    if (c_div == H - 1) begin
      c_div = 0;
      m_sclk = !m_sclk;
    end else begin
      c_div++;
    end
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic frame(int nbytes, int cycles);
    frame_bytes = 8'(nbytes);
    seen_valid = 0;
    seen_last = 0;
    fr_go = 1;
    run(cycles);
    chk("R7", "bytes in frame", 8'(seen_valid), 8'(nbytes));
    chk("R7", "last flags in frame", 8'(seen_last), (nbytes > 0) ? 8'd1 : 8'd0);
    chk("R5", "sender queue drained", 8'(exp_q.size()), 8'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R2", "sclk in reset", sclk, 0);
    chk("R2", "frm in reset", frm, 0);
    chk("R2", "dreq in reset", dreq, 0);
    chk("R2", "byte_valid in reset", byte_valid, 0);
    chk("R2", "byte_last in reset", byte_last, 0);
    chk("R2", "strobe_err in reset", strobe_err, 0);
    rst_n = 1;
    rdy = 1;
    frame_bytes = 8'd3;
    run(60);
    chk("R10", "no request before frame", dreq, 0);

    frame(3, 400);

    rnd_avail = 1;
    mid_inj = 1;
    frame(4, 900);
    chk("R9", "no error after strobe inside byte", strobe_err, 0);

    rnd_avail = 0;
    frame_bytes = 8'd5;
    seen_valid = 0;
    seen_last = 0;
    fr_go = 1;
    run(150);
    rdy = 0;
    run(200);
    rdy = 1;
    run(500);
    chk("R7", "bytes in paused frame", 8'(seen_valid), 8'd5);
    chk("R7", "last flags in paused frame", 8'(seen_last), 8'd1);

    frame(0, 120);

    stray = 1;
    run(60);
    chk("R8", "error after unrequested strobe", strobe_err, 1);
    chk("R8", "no byte from unrequested strobe", 8'(seen_valid), 8'd0);
    run(40);
    chk("R8", "error stays set", strobe_err, 1);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule